// File: doc/BRIEF.md
# GPIO Pad Level Resolver and Sense Path

This block models one bank of general-purpose pins as a single datapath. A small register write port holds the per-pin configuration: output value, driver enable, driver type (push-pull or open-drain), pull-up selection, polarity inversion and input sense enable. From these the block computes the level each pin settles at and the value software would sample back from it.

Polarity sits on both sides of the pin. The output value is inverted on its way to the driver, and the sensed level is inverted again on its way back. A push-pull pin that drives therefore reads back its own output value. An open-drain pin can only pull low; when its inverted output is 1 it releases the pin, which then rests at the pull level. A pin whose sense enable is cleared reads as 0 before the inversion is applied. Both outputs are combinational from the configuration registers. Set and clear aliases change single bits of the output value and driver enable without a read-modify-write.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset the output value, driver enable, driver type and polarity are all zero, and pull-up and sense enable are all ones. Both `pad_level` and `din_value` therefore read all ones.
- R2: For a pin whose driver is enabled in push-pull type (type bit 0), `pad_level` equals output XOR polarity, and `din_value` equals the output value whenever the sense enable bit is 1.
- R3: For a pin whose driver is disabled, `pad_level` equals its pull-up bit, whatever its output value and driver type bits are.
- R4: For a pin whose driver is enabled in open-drain type (type bit 1), `pad_level` is 0 when output XOR polarity is 0, and equals the pull-up bit when it is 1.
- R5: `din_value` equals (`pad_level` AND sense enable) XOR polarity. A pin with sense enable 0 reads its polarity bit.
- R6: A write to byte offset 0x68 sets the output-value bits where the data is 1, and a write to 0x6C clears them. The other bits keep their values.
- R7: A write to byte offset 0x70 sets the driver-enable bits where the data is 1, and a write to 0x74 clears them. The other bits keep their values.
- R8: Whole-register writes take effect at the clock edge that samples `wr_en`, and both outputs show the result from the following cycle on. The byte offsets are: polarity 0x08, output value 0x0C, driver enable 0x10, driver type 0x14, pull-up 0x1C, sense enable 0x58.
- R9: A write to the sense readback offset 0x04 changes nothing. So does a write to an unmapped offset, or to a byte address whose two low bits are not zero.
- R10: Offset 0x20 (pull-down) is accepted and has no effect on either output. A floating pin rests at its pull-up bit whether the pull-down bit is its complement, equal to it, or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | WIDTH | Write data |
| pad_level | output | WIDTH | Resolved level of each pin |
| din_value | output | WIDTH | Sensed value read back for each pin |

## Verification
The bench builds the block with WIDTH = 32 and ADDR_W = 7. At these values every mapped offset, including the set and clear aliases at the top of the window, sits inside the address space, and the seven-bit address still leaves room for unmapped, read-only and misaligned targets. A 32-pin bank also lets one directed vector mix drive, float, open-drain and masked pins at once. Random writes are applied across all the offsets, and after each write the bench compares both outputs against its own model of the pin rules.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    // Word index (byte offset >> 2) of each decoded register
    localparam logic [4:0] IDX_INVERT  = 5'h02;
    localparam logic [4:0] IDX_OUTVAL  = 5'h03;
    localparam logic [4:0] IDX_DRVEN   = 5'h04;
    localparam logic [4:0] IDX_DRVTYPE = 5'h05;
    localparam logic [4:0] IDX_PULLUP  = 5'h07;
    localparam logic [4:0] IDX_SENSEEN = 5'h16;
    localparam logic [4:0] IDX_OUT_SET = 5'h1A;
    localparam logic [4:0] IDX_OUT_CLR = 5'h1B;
    localparam logic [4:0] IDX_DRV_SET = 5'h1C;
    localparam logic [4:0] IDX_DRV_CLR = 5'h1D;

    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned MIN_ADDR_W = IDX_LSB + IDX_W;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_INV_WR,
        OP_OUT_WR,
        OP_DRV_WR,
        OP_TYPE_WR,
        OP_PU_WR,
        OP_SENSE_WR,
        OP_OUT_SET,
        OP_OUT_CLR,
        OP_DRV_SET,
        OP_DRV_CLR
    } wr_op_e;

    // Per-pin driver-side configuration
    typedef struct packed {
        logic outval;
        logic drv_en;
        logic open_drain;
        logic pull_up;
        logic invert;
    } pin_drv_t;

    function automatic wr_op_e decode_op(input logic [IDX_W-1:0] idx, input logic legal);
        wr_op_e op;
        op = OP_NONE;
        if (legal) begin
            case (idx)
                IDX_INVERT:  op = OP_INV_WR;
                IDX_OUTVAL:  op = OP_OUT_WR;
                IDX_DRVEN:   op = OP_DRV_WR;
                IDX_DRVTYPE: op = OP_TYPE_WR;
                IDX_PULLUP:  op = OP_PU_WR;
                IDX_SENSEEN: op = OP_SENSE_WR;
                IDX_OUT_SET: op = OP_OUT_SET;
                IDX_OUT_CLR: op = OP_OUT_CLR;
                IDX_DRV_SET: op = OP_DRV_SET;
                IDX_DRV_CLR: op = OP_DRV_CLR;
                default:     op = OP_NONE;
            endcase
        end
        return op;
    endfunction

    // Level a released pin settles at: the pull-up selection in every case
    function automatic logic float_level(input pin_drv_t c);
        return c.pull_up;
    endfunction

    function automatic logic pad_bit(input pin_drv_t c);
        logic driven;
        logic lvl;
        driven = c.outval ^ c.invert;
        if (!c.drv_en) begin
            lvl = float_level(c);
        end else if (!c.open_drain) begin
            lvl = driven;
        end else begin
            lvl = driven ? float_level(c) : 1'b0;
        end
        return lvl;
    endfunction

    function automatic logic sense_bit(input logic pad, input logic en, input logic inv);
        return (pad & en) ^ inv;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pad_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  outval_q,
    output logic [WIDTH-1:0]  drven_q,
    output logic [WIDTH-1:0]  drvtype_q,
    output logic [WIDTH-1:0]  pullup_q,
    output logic [WIDTH-1:0]  invert_q,
    output logic [WIDTH-1:0]  senseen_q
);

    localparam int unsigned HI_SHIFT = MIN_ADDR_W;

    logic              aligned;
    logic              in_window;
    logic [IDX_W-1:0]  word_idx;
    wr_op_e            op;

    assign aligned   = (wr_addr[IDX_LSB-1:0] == '0);
    assign in_window = ((wr_addr >> HI_SHIFT) == '0);
    assign word_idx  = wr_addr[IDX_LSB +: IDX_W];
    assign op        = decode_op(word_idx, wr_en && aligned && in_window);

    always_ff @(posedge clk) begin
        if (rst) begin
            outval_q  <= '0;
            drven_q   <= '0;
            drvtype_q <= '0;
            pullup_q  <= '1;
            invert_q  <= '0;
            senseen_q <= '1;
        end else begin
            case (op)
                OP_INV_WR:   invert_q  <= wr_data;
                OP_OUT_WR:   outval_q  <= wr_data;
                OP_DRV_WR:   drven_q   <= wr_data;
                OP_TYPE_WR:  drvtype_q <= wr_data;
                OP_PU_WR:    pullup_q  <= wr_data;
                OP_SENSE_WR: senseen_q <= wr_data;
                OP_OUT_SET:  outval_q  <= outval_q | wr_data;
                OP_OUT_CLR:  outval_q  <= outval_q & ~wr_data;
                OP_DRV_SET:  drven_q   <= drven_q | wr_data;
                OP_DRV_CLR:  drven_q   <= drven_q & ~wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve
    import gpio_pad_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  pin_drv_t [WIDTH-1:0] pin_cfg,
    output logic     [WIDTH-1:0] pad
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad[i] = pad_bit(pin_cfg[i]);
    end

endmodule

// File: rtl/gpio_pad_sense.sv
module gpio_pad_sense
    import gpio_pad_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] pad,
    input  logic [WIDTH-1:0] sense_en,
    input  logic [WIDTH-1:0] invert,
    output logic [WIDTH-1:0] din
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign din[i] = sense_bit(pad[i], sense_en[i], invert[i]);
    end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  pad_level,
    output logic [WIDTH-1:0]  din_value
);

    logic [WIDTH-1:0] outval_q;
    logic [WIDTH-1:0] drven_q;
    logic [WIDTH-1:0] drvtype_q;
    logic [WIDTH-1:0] pullup_q;
    logic [WIDTH-1:0] invert_q;
    logic [WIDTH-1:0] senseen_q;

    pin_drv_t [WIDTH-1:0] pin_cfg;

    gpio_cfg_regs #(
        .WIDTH  (WIDTH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .outval_q  (outval_q),
        .drven_q   (drven_q),
        .drvtype_q (drvtype_q),
        .pullup_q  (pullup_q),
        .invert_q  (invert_q),
        .senseen_q (senseen_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cfg
        assign pin_cfg[i].outval     = outval_q[i];
        assign pin_cfg[i].drv_en     = drven_q[i];
        assign pin_cfg[i].open_drain = drvtype_q[i];
        assign pin_cfg[i].pull_up    = pullup_q[i];
        assign pin_cfg[i].invert     = invert_q[i];
    end

    gpio_pad_resolve #(
        .WIDTH (WIDTH)
    ) u_resolve (
        .pin_cfg (pin_cfg),
        .pad     (pad_level)
    );

    gpio_pad_sense #(
        .WIDTH (WIDTH)
    ) u_sense (
        .pad      (pad_level),
        .sense_en (senseen_q),
        .invert   (invert_q),
        .din      (din_value)
    );

endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  pad_level,
    input logic [WIDTH-1:0]  din_value,
    input logic [WIDTH-1:0]  outval_q,
    input logic [WIDTH-1:0]  drven_q,
    input logic [WIDTH-1:0]  drvtype_q,
    input logic [WIDTH-1:0]  pullup_q,
    input logic [WIDTH-1:0]  invert_q,
    input logic [WIDTH-1:0]  senseen_q
);

    localparam logic [ADDR_W-1:0] A_READBACK = ADDR_W'(7'h04);
    localparam logic [ADDR_W-1:0] A_DRV_SET  = ADDR_W'(7'h70);

    logic armed;
    logic [WIDTH-1:0] pp_drv;
    logic [WIDTH-1:0] od_low;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign pp_drv = drven_q & ~drvtype_q & senseen_q;
    assign od_low = drven_q & drvtype_q & ~(outval_q ^ invert_q);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (pad_level == '1 && din_value == '1));

    // R2
    pushpull_echo_chk: assert property (@(posedge clk) disable iff (rst)
        ((din_value ^ outval_q) & pp_drv) == '0);

    // R3
    released_pull_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_level ^ pullup_q) & ~drven_q) == '0);

    // R4
    opendrain_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_level & od_low) == '0);

    // R5
    masked_sense_chk: assert property (@(posedge clk) disable iff (rst)
        ((din_value ^ invert_q) & ~senseen_q) == '0);

    // R7
    drv_set_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DRV_SET) |=> drven_q == ($past(drven_q) | $past(wr_data)));

    // R9
    readback_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_READBACK) |=>
            ($stable(outval_q) && $stable(drven_q) && $stable(drvtype_q) &&
             $stable(pullup_q) && $stable(invert_q) && $stable(senseen_q)));

endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pad_level (pad_level),
    .din_value (din_value),
    .outval_q  (outval_q),
    .drven_q   (drven_q),
    .drvtype_q (drvtype_q),
    .pullup_q  (pullup_q),
    .invert_q  (invert_q),
    .senseen_q (senseen_q)
);

// File: tb/sim_gpio_pad_bank.sv
module sim_gpio_pad_bank;

    localparam int W  = 32;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  pad_level;
    logic [W-1:0]  din_value;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the configuration
    logic [W-1:0] m_out, m_drv, m_od, m_pu, m_inv, m_sen;

    always #10 clk = ~clk;

    gpio_pad_bank #(.WIDTH(W), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pad_level (pad_level),
        .din_value (din_value)
    );

    function automatic logic [W-1:0] want_pad();
        logic [W-1:0] drive;
        drive = m_out ^ m_inv;
        return (~m_drv & m_pu) | (m_drv & ~m_od & drive) | (m_drv & m_od & drive & m_pu);
    endfunction

    function automatic logic [W-1:0] want_din();
        return (want_pad() & m_sen) ^ m_inv;
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        case (a)
            7'h08: m_inv = d;
            7'h0C: m_out = d;
            7'h10: m_drv = d;
            7'h14: m_od  = d;
            7'h1C: m_pu  = d;
            7'h58: m_sen = d;
            7'h68: m_out = m_out | d;
            7'h6C: m_out = m_out & ~d;
            7'h70: m_drv = m_drv | d;
            7'h74: m_drv = m_drv & ~d;
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_model(input string tag);
        check({tag, " pad"}, pad_level, want_pad());
        check({tag, " din"}, din_value, want_din());
    endtask

    initial begin
        #5_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] before_pad, before_din;
        logic [AW-1:0] pick [14];
        void'($urandom(32'd2718));
        m_out = '0; m_drv = '0; m_od = '0; m_pu = '1; m_inv = '0; m_sen = '1;
        pick = '{7'h08, 7'h0C, 7'h10, 7'h14, 7'h1C, 7'h20, 7'h58,
                 7'h68, 7'h6C, 7'h70, 7'h74, 7'h04, 7'h7C, 7'h11};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset pad", pad_level, 32'hFFFF_FFFF);
        check("R1 reset din", din_value, 32'hFFFF_FFFF);

        // R2 push-pull echo, no inversion
        wr(7'h10, 32'hFFFF_FFFF);
        wr(7'h0C, 32'h3C5A_96E1);
        check("R2 pad plain", pad_level, 32'h3C5A_96E1);
        check("R2 din plain", din_value, 32'h3C5A_96E1);

        // R8 write is not visible before its edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h08; wr_data = 32'h0FF0_A55A;
        #1 check("R8 before edge", pad_level, 32'h3C5A_96E1);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(7'h08, 32'h0FF0_A55A);
        // R2 inversion on both sides
        check("R8 after edge", pad_level, 32'h3C5A_96E1 ^ 32'h0FF0_A55A);
        check("R2 din inverted", din_value, 32'h3C5A_96E1);

        // R3 released pins follow pull-up
        wr(7'h08, 32'h0);
        wr(7'h10, 32'h0);
        wr(7'h1C, 32'h5A5A_0F0F);
        wr(7'h20, 32'hA5A5_F0F0);
        check("R3 pad released", pad_level, 32'h5A5A_0F0F);
        wr(7'h14, 32'hFFFF_FFFF);
        wr(7'h0C, 32'h1234_5678);
        check("R3 pad type/out ignored", pad_level, 32'h5A5A_0F0F);

        // R10 pull-down has no effect
        wr(7'h20, 32'h5A5A_0F0F);
        check("R10 pad pd equal", pad_level, 32'h5A5A_0F0F);
        wr(7'h20, 32'h0);
        check("R10 pad pd clear", pad_level, 32'h5A5A_0F0F);

        // R4 open drain
        wr(7'h1C, 32'hFFFF_0000);
        wr(7'h10, 32'hFFFF_FFFF);
        wr(7'h0C, 32'hF0F0_F0F0);
        check("R4 pad open-drain", pad_level, 32'hF0F0_0000);
        wr(7'h08, 32'hFFFF_FFFF);
        check("R4 pad open-drain inverted", pad_level, 32'h0F0F_0000);

        // R5 sense enable masking before inversion
        wr(7'h14, 32'h0);
        wr(7'h0C, 32'hAAAA_5555);
        wr(7'h08, 32'h0F0F_0F0F);
        wr(7'h58, 32'h0000_FFFF);
        check("R5 din masked", din_value, 32'h0F0F_5555);
        wr(7'h58, 32'hFFFF_FFFF);
        wr(7'h08, 32'h0);

        // R6 output set/clear aliases
        wr(7'h0C, 32'h0000_00F0);
        wr(7'h68, 32'h0000_0F01);
        check("R6 din out set", din_value, 32'h0000_0FF1);
        wr(7'h6C, 32'h0000_00F0);
        check("R6 din out clear", din_value, 32'h0000_0F01);

        // R7 driver enable set/clear aliases
        wr(7'h0C, 32'hFFFF_FFFF);
        wr(7'h1C, 32'h0);
        wr(7'h10, 32'h1234_0000);
        wr(7'h74, 32'h0030_0000);
        check("R7 pad drv clear", pad_level, 32'h1204_0000);
        wr(7'h70, 32'h0000_000F);
        check("R7 pad drv set", pad_level, 32'h1204_000F);

        // R9 ignored targets
        before_pad = pad_level;
        before_din = din_value;
        wr(7'h04, 32'h0000_0000);
        check("R9 readback offset pad", pad_level, before_pad);
        wr(7'h7C, 32'hFFFF_FFFF);
        check("R9 unmapped offset pad", pad_level, before_pad);
        wr(7'h11, 32'h0);
        check("R9 unaligned pad", pad_level, before_pad);
        wr(7'h0D, 32'h0);
        check("R9 unaligned din", din_value, before_din);

        // R2 R3 R4 R5 R6 R7 R9 random mix
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            a = pick[$urandom_range(0, 13)];
            wr(a, $urandom());
            check_model("R8 random");
        end

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_out = '0; m_drv = '0; m_od = '0; m_pu = '1; m_inv = '0; m_sen = '1;
        @(negedge clk);
        check("R1 re-reset pad", pad_level, 32'hFFFF_FFFF);
        check("R1 re-reset din", din_value, 32'hFFFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule